// File: doc/BRIEF.md
# Asynchronous Serial Frame Engine

This block is the character engine of a serial port. A transmit path takes one character at a time from a holding register, serialises it onto an idle-high line and reports when the holding register has been consumed and when the last stop bit has left. A receive path watches the incoming line, rebuilds characters and places each in a single read buffer. Bit timing comes from an enable pulse supplied by an external baud generator at sixteen times the bit rate. The block has no FIFOs: one character is held on each side.

The frame format comes from a configuration word. It selects one of three data/parity layouts, one or two stop bits, odd or even parity, whether parity is checked, and whether framing and overrun errors are recorded. Framing, parity and overrun errors are held in sticky flags. Software never changes these flags by read-modify-write. A separate command word carries one-cycle strobes: turn the receiver on, turn it off, and clear each error flag.

Top module: `uart_frame_core`

## Requirements
- R1: After reset, txd is 1, tx_busy is 0, rx_valid is 0, rx_enabled is 0, and all three error flags are 0. The configuration resets to 8 data bits, no parity, 1 stop bit, with no error checks.
- R2: cfg_wdata[1:0] selects the format: 00 is 8 data bits with no parity, 01 is 7 data bits plus parity, 10 is 8 data bits plus parity. A configuration write carrying code 11 is dropped in full, so the previous configuration stays.
- R3: A transmitted frame is one low start bit, then the data bits LSB first, then the parity bit if the format has one, then the stop bits at 1. cfg_wdata[2]=1 gives 2 stop bits and 0 gives 1. Each bit lasts 16 oversampling ticks. tx_done_pulse is high for one cycle when the last stop bit ends, and the line is high while tx_busy is 0.
- R4: tx_empty_pulse is high for one cycle when the holding register moves into the shifter. A write while a character is still pending replaces it.
- R5: Command bit 0 turns the receiver on and command bit 1 turns it off. While the receiver is off, no character reaches the read buffer.
- R6: The receiver starts a frame on a falling edge and confirms the start bit at the 8th tick. A low pulse shorter than that is ignored. Every later bit is sampled at mid-bit.
- R7: In the 7-bit format, rx_data[7] is 0 and the data sits in rx_data[6:0].
- R8: The parity bit makes the number of ones in data plus parity even when cfg_wdata[4]=0 and odd when it is 1. With cfg_wdata[3]=1, a received mismatch sets err_parity. The character is still delivered.
- R9: With cfg_wdata[5]=1, a received stop bit sampled low sets err_frame. With cfg_wdata[5]=0 it does not.
- R10: When a character completes while rx_valid is still 1, the new character is discarded and rx_data keeps the old one. err_overrun is set only when cfg_wdata[6]=1.
- R11: Each error flag holds until its clear strobe: command bit 2 clears err_frame, bit 3 clears err_parity, bit 4 clears err_overrun. Reads do not clear them. If a flag's set and its clear strobe fall in the same cycle, the set wins.
- R12: rx_rd empties the read buffer on the next edge. Until then, rx_valid and rx_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Format and error-check configuration |
| cmd_we | input | 1 | Command strobe write |
| cmd_wdata | input | 5 | Receiver on/off and flag-clear strobes |
| tx_we | input | 1 | Holding register write |
| tx_wdata | input | DATA_W | Character to send |
| tx_busy | output | 1 | Shifter is sending a frame |
| tx_empty_pulse | output | 1 | Holding register taken by the shifter |
| tx_done_pulse | output | 1 | Last stop bit finished |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_rd | input | 1 | Read buffer consumed |
| rx_valid | output | 1 | Read buffer holds a character |
| rx_data | output | DATA_W | Received character |
| rx_enabled | output | 1 | Receiver is on |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
The conflict that needs care is an error being set in the same cycle as the strobe that clears it. The bench holds the overrun clear strobe active during a whole incoming character that arrives while the buffer is full. The set has priority, so err_overrun must rise for at least one cycle inside that window and then be 0 once the strobe is released. A clear-first design would never show the flag at all.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;

  typedef enum logic [1:0] {
    FMT_8_NOPAR = 2'b00,
    FMT_7_PAR   = 2'b01,
    FMT_8_PAR   = 2'b10,
    FMT_BAD     = 2'b11
  } fmt_e;

  // packed order puts fmt in the low two bits
  typedef struct packed {
    logic ovr_chk;
    logic frm_chk;
    logic odd;
    logic par_chk;
    logic two_stop;
    fmt_e fmt;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  localparam int CMD_RX_ON  = 0;
  localparam int CMD_RX_OFF = 1;
  localparam int CMD_CLR_FE = 2;
  localparam int CMD_CLR_PE = 3;
  localparam int CMD_CLR_OE = 4;
  localparam int CMD_W      = 5;

  localparam int NUM_FLAGS  = 3;
  localparam int FLG_FE     = 0;
  localparam int FLG_PE     = 1;
  localparam int FLG_OE     = 2;

endpackage

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_fmt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  cfg_t              cfg,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              txd,
  output logic              busy,
  output logic              empty_pulse,
  output logic              done_pulse
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);

  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_e;

  tst_e              st_q;
  logic [DATA_W-1:0] hold_q, sh_q;
  logic              hold_full_q, par_q, stop2_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  idx_q;
  logic [BIT_W-1:0]  last_idx;
  logic [DATA_W-1:0] dmask;
  logic              bit_end;

  always_comb begin
    last_idx = (cfg.fmt == FMT_7_PAR) ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1);
    dmask    = (cfg.fmt == FMT_7_PAR) ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    bit_end  = tick && (cnt_q == LAST_TICK);
  end

  assign busy = (st_q != T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= T_IDLE;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      sh_q        <= '0;
      par_q       <= 1'b0;
      stop2_q     <= 1'b0;
      cnt_q       <= '0;
      idx_q       <= '0;
      txd         <= 1'b1;
      empty_pulse <= 1'b0;
      done_pulse  <= 1'b0;
    end else begin
      empty_pulse <= 1'b0;
      done_pulse  <= 1'b0;
      if (st_q != T_IDLE && tick)
        cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
      case (st_q)
        T_IDLE: begin
          if (hold_full_q) begin
            sh_q        <= hold_q;
            par_q       <= (^(hold_q & dmask)) ^ cfg.odd;
            st_q        <= T_START;
            cnt_q       <= '0;
            txd         <= 1'b0;
            empty_pulse <= 1'b1;
            hold_full_q <= 1'b0;
          end
        end
        T_START: begin
          if (bit_end) begin
            st_q  <= T_DATA;
            txd   <= sh_q[0];
            sh_q  <= sh_q >> 1;
            idx_q <= '0;
          end
        end
        T_DATA: begin
          if (bit_end) begin
            if (idx_q == last_idx) begin
              stop2_q <= 1'b0;
              if (cfg.fmt != FMT_8_NOPAR) begin
                st_q <= T_PAR;
                txd  <= par_q;
              end else begin
                st_q <= T_STOP;
                txd  <= 1'b1;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
              txd   <= sh_q[0];
              sh_q  <= sh_q >> 1;
            end
          end
        end
        T_PAR: begin
          if (bit_end) begin
            st_q    <= T_STOP;
            txd     <= 1'b1;
            stop2_q <= 1'b0;
          end
        end
        T_STOP: begin
          if (bit_end) begin
            if (cfg.two_stop && !stop2_q) begin
              stop2_q <= 1'b1;
            end else begin
              st_q       <= T_IDLE;
              done_pulse <= 1'b1;
            end
          end
        end
        default: st_q <= T_IDLE;
      endcase
      if (wr) begin
        hold_q      <= wdata;
        hold_full_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_fmt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic              rxd,
  input  cfg_t              cfg,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_bad,
  output logic              frm_bad
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OSR / 2 - 1);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rst_e;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s, rx_prev;
  rst_e                   st_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [BIT_W-1:0]       idx_q;
  logic [DATA_W-1:0]      sh_q;
  logic                   acc_q, pbad_q, fbad_q, stop2_q;
  logic [BIT_W-1:0]       last_idx;
  logic                   seven;

  assign rx_s     = sync_q[SYNC_STAGES-1];
  assign seven    = (cfg.fmt == FMT_7_PAR);
  assign last_idx = seven ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      rx_prev <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], rxd};
      rx_prev <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= R_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      pbad_q  <= 1'b0;
      fbad_q  <= 1'b0;
      stop2_q <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      par_bad <= 1'b0;
      frm_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st_q <= R_IDLE;
      end else begin
        case (st_q)
          R_IDLE: begin
            if (rx_prev && !rx_s) begin
              st_q  <= R_START;
              cnt_q <= '0;
            end
          end
          R_START: begin
            if (tick) begin
              if (cnt_q == MID_TICK) begin
                cnt_q <= '0;
                if (!rx_s) begin
                  st_q    <= R_DATA;
                  idx_q   <= '0;
                  sh_q    <= '0;
                  acc_q   <= 1'b0;
                  pbad_q  <= 1'b0;
                  fbad_q  <= 1'b0;
                  stop2_q <= 1'b0;
                end else begin
                  st_q <= R_IDLE;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          R_DATA: begin
            if (tick) begin
              if (cnt_q == LAST_TICK) begin
                cnt_q <= '0;
                sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
                acc_q <= acc_q ^ rx_s;
                if (idx_q == last_idx)
                  st_q <= (cfg.fmt != FMT_8_NOPAR) ? R_PAR : R_STOP;
                else
                  idx_q <= idx_q + 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          R_PAR: begin
            if (tick) begin
              if (cnt_q == LAST_TICK) begin
                cnt_q  <= '0;
                pbad_q <= acc_q ^ rx_s ^ cfg.odd;
                st_q   <= R_STOP;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          R_STOP: begin
            if (tick) begin
              if (cnt_q == LAST_TICK) begin
                cnt_q <= '0;
                if (cfg.two_stop && !stop2_q) begin
                  stop2_q <= 1'b1;
                  if (!rx_s) fbad_q <= 1'b1;
                end else begin
                  st_q    <= R_IDLE;
                  done    <= 1'b1;
                  data    <= seven ? {1'b0, sh_q[DATA_W-1:1]} : sh_q;
                  par_bad <= (cfg.fmt != FMT_8_NOPAR) && pbad_q;
                  frm_bad <= fbad_q | !rx_s;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: st_q <= R_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_fmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cfg_t              cfg,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  input  logic              par_bad,
  input  logic              frm_bad,
  input  logic              rd,
  output logic              rx_en,
  output logic              valid,
  output logic [DATA_W-1:0] rbuf,
  output logic [NUM_FLAGS-1:0] flags
);
  logic                 accept, free;
  logic [NUM_FLAGS-1:0] set_v, clr_v;

  assign accept = done && rx_en;
  assign free   = !valid || rd;

  always_comb begin
    set_v         = '0;
    set_v[FLG_FE] = accept && frm_bad && cfg.frm_chk;
    set_v[FLG_PE] = accept && par_bad && cfg.par_chk;
    set_v[FLG_OE] = accept && !free && cfg.ovr_chk;
    clr_v         = '0;
    clr_v[FLG_FE] = cmd_we && cmd[CMD_CLR_FE];
    clr_v[FLG_PE] = cmd_we && cmd[CMD_CLR_PE];
    clr_v[FLG_OE] = cmd_we && cmd[CMD_CLR_OE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en <= 1'b0;
    end else if (cmd_we && cmd[CMD_RX_ON]) begin
      rx_en <= 1'b1;
    end else if (cmd_we && cmd[CMD_RX_OFF]) begin
      rx_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      rbuf  <= '0;
    end else begin
      if (rd) valid <= 1'b0;
      if (accept && free) begin
        valid <= 1'b1;
        rbuf  <= data;
      end
    end
  end

  // one sticky cell per error kind; a set outranks its clear
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flags[i] <= 1'b0;
      else if (set_v[i]) flags[i] <= 1'b1;
      else if (clr_v[i]) flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_frame_core.sv
module uart_frame_core
  import uart_fmt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic              tx_busy,
  output logic              tx_empty_pulse,
  output logic              tx_done_pulse,
  output logic              txd,
  input  logic              rxd,
  input  logic              rx_rd,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_enabled,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  cfg_t                 cfg_q, cfg_in;
  logic                 rs_done, rs_pbad, rs_fbad;
  logic [DATA_W-1:0]    rs_data;
  logic [NUM_FLAGS-1:0] flags;

  assign cfg_in = cfg_t'(cfg_wdata);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (cfg_we && cfg_in.fmt != FMT_BAD) cfg_q <= cfg_in;
  end

  uart_tx_shifter #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick16), .cfg(cfg_q),
    .wr(tx_we), .wdata(tx_wdata), .txd(txd), .busy(tx_busy),
    .empty_pulse(tx_empty_pulse), .done_pulse(tx_done_pulse)
  );

  uart_rx_sampler #(.DATA_W(DATA_W), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .tick(tick16), .en(rx_enabled), .rxd(rxd),
    .cfg(cfg_q), .done(rs_done), .data(rs_data),
    .par_bad(rs_pbad), .frm_bad(rs_fbad)
  );

  uart_rx_status #(.DATA_W(DATA_W)) u_st (
    .clk(clk), .rst(rst), .cfg(cfg_q), .cmd_we(cmd_we), .cmd(cmd_wdata),
    .done(rs_done), .data(rs_data), .par_bad(rs_pbad), .frm_bad(rs_fbad),
    .rd(rx_rd), .rx_en(rx_enabled), .valid(rx_valid), .rbuf(rx_data),
    .flags(flags)
  );

  assign err_frame   = flags[FLG_FE];
  assign err_parity  = flags[FLG_PE];
  assign err_overrun = flags[FLG_OE];

endmodule

// File: rtl/uart_frame_core_chk.sv
module uart_frame_core_chk
  import uart_fmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_we,
  input logic [CMD_W-1:0]  cmd_wdata,
  input logic              tx_busy,
  input logic              tx_empty_pulse,
  input logic              tx_done_pulse,
  input logic              txd,
  input logic              rx_rd,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_enabled,
  input logic              err_frame,
  input logic              err_parity,
  input logic              err_overrun
);

  assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  assert_done_leaves_idle_R3: assert property (@(posedge clk) disable iff (rst)
    tx_done_pulse |-> !tx_busy);

  assert_empty_single_R4: assert property (@(posedge clk) disable iff (rst)
    tx_empty_pulse |=> !tx_empty_pulse);

  assert_rx_off_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!rx_enabled && !rx_valid) |=> !rx_valid);

  assert_buffer_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_rd) |=> (rx_valid && $stable(rx_data)));

  assert_fe_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (err_frame && !(cmd_we && cmd_wdata[CMD_CLR_FE])) |=> err_frame);

  assert_pe_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (err_parity && !(cmd_we && cmd_wdata[CMD_CLR_PE])) |=> err_parity);

  assert_oe_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (err_overrun && !(cmd_we && cmd_wdata[CMD_CLR_OE])) |=> err_overrun);

endmodule

bind uart_frame_core uart_frame_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .tx_busy(tx_busy), .tx_empty_pulse(tx_empty_pulse),
  .tx_done_pulse(tx_done_pulse), .txd(txd), .rx_rd(rx_rd),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_enabled(rx_enabled),
  .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
);

// File: tb/sim_uart_frame_core.sv
module sim_uart_frame_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b1;   // oversampling enable held high: one bit = 16 clocks
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic       cmd_we = 1'b0;
  logic [4:0] cmd_wdata = '0;
  logic       tx_we = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic       tx_busy, tx_empty_pulse, tx_done_pulse, txd;
  logic       rx_rd = 1'b0;
  logic       rx_valid, rx_enabled, err_frame, err_parity, err_overrun;
  logic [7:0] rx_data;
  logic       loop_en = 1'b1;
  logic       drv_rxd = 1'b1;
  logic       rxd;

  int         n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  bit         auto_rd = 1'b1;
  bit         man_rd_req = 1'b0;
  bit         watch_oe = 1'b0, seen_oe = 1'b0;
  int         n_empty = 0, n_done = 0;
  logic [6:0] cur_cfg = '0;

  assign rxd = loop_en ? txd : drv_rxd;
  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_core u0 (
    .clk(clk), .rst(rst), .tick16(tick16), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .tx_we(tx_we), .tx_wdata(tx_wdata),
    .tx_busy(tx_busy), .tx_empty_pulse(tx_empty_pulse), .tx_done_pulse(tx_done_pulse),
    .txd(txd), .rxd(rxd), .rx_rd(rx_rd), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_enabled(rx_enabled), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dmask(input logic [6:0] c);
    return (c[1:0] == 2'b01) ? 8'h7F : 8'hFF;
  endfunction

  // expected line image, bit k = k-th bit period on the wire (R3, R8)
  function automatic void build_frame(input logic [7:0] d, input logic [6:0] c,
                                      output logic [15:0] f, output int n);
    int nd = (c[1:0] == 2'b01) ? 7 : 8;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[1+i] = d[i];
    n = 1 + nd;
    if (c[1:0] != 2'b00) begin
      f[n] = (^(d & dmask(c))) ^ c[4];
      n++;
    end
    n += c[2] ? 2 : 1;
  endfunction

  // scoreboard monitor: sole driver of rx_rd
  always @(negedge clk) begin
    if (watch_oe && err_overrun) seen_oe = 1'b1;
    if (tx_empty_pulse) n_empty++;
    if (tx_done_pulse) n_done++;
    if (rx_rd) begin
      rx_rd = 1'b0;
    end else if (man_rd_req) begin
      rx_rd = 1'b1;
      man_rd_req = 1'b0;
    end else if (auto_rd && rx_valid) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected character", {24'h0, rx_data}, 32'hFFFF_FFFF);
      end else begin
        chk("R3/R7 received data", {24'h0, rx_data}, {24'h0, exp_q.pop_front()});
      end
      rx_rd = 1'b1;
    end
  end

  task automatic cfg_write(input logic [6:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    if (v[1:0] != 2'b11) cur_cfg = v;
  endtask

  task automatic cmd_write(input logic [4:0] v);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic read_buf();
    man_rd_req = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] d, input bit expect_rx, input string tag);
    logic [15:0] f;
    int n;
    int bad = 0;
    build_frame(d, cur_cfg, f, n);
    if (expect_rx) exp_q.push_back(d & dmask(cur_cfg));
    @(negedge clk); tx_we = 1'b1; tx_wdata = d;
    @(negedge clk); tx_we = 1'b0;
    while (!tx_empty_pulse) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      repeat (8) @(negedge clk);
      if (txd !== f[k]) bad++;
      repeat (8) @(negedge clk);
    end
    chk({tag, " line bits"}, bad, 0);
    chk("R3 done pulse after last stop", tx_done_pulse, 1'b1);
    repeat (6) @(negedge clk);
  endtask

  task automatic send_raw(input logic [7:0] d, input bit flip_par, input logic stop_v);
    logic [15:0] f;
    int n;
    int nd = (cur_cfg[1:0] == 2'b01) ? 7 : 8;
    build_frame(d, cur_cfg, f, n);
    if (flip_par && cur_cfg[1:0] != 2'b00) f[1+nd] = ~f[1+nd];
    f[n - (cur_cfg[2] ? 2 : 1)] = stop_v;
    for (int k = 0; k < n; k++) begin
      drv_rxd = f[k];
      repeat (16) @(negedge clk);
    end
    drv_rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 tx_busy", tx_busy, 1'b0);
    chk("R1 rx_valid", rx_valid, 1'b0);
    chk("R1 rx_enabled", rx_enabled, 1'b0);
    chk("R1 flags", {err_frame, err_parity, err_overrun}, 3'b000);

    // receiver off: loopback frame must not arrive
    send_tx(8'h5A, 1'b0, "R3 8N1 while rx off");
    chk("R5 nothing received while off", rx_valid, 1'b0);
    cmd_write(5'b00001);
    chk("R5 receiver on", rx_enabled, 1'b1);

    // 8 data, no parity, 1 stop, framing+overrun checks
    cfg_write(7'h60);
    send_tx(8'h5A, 1'b1, "R3 8N1 5A");
    send_tx(8'hA5, 1'b1, "R3 8N1 A5");
    send_tx(8'h00, 1'b1, "R3 8N1 00");
    send_tx(8'hFF, 1'b1, "R3 8N1 FF");

    // 7 data + even parity
    cfg_write(7'h69);
    send_tx(8'hC3, 1'b1, "R7 7E1 C3");
    send_tx(8'h7F, 1'b1, "R8 7E1 7F");

    // 8 data + odd parity + 2 stops
    cfg_write(7'h7E);
    send_tx(8'h96, 1'b1, "R8 8O2 96");
    send_tx(8'h01, 1'b1, "R3 8O2 01");

    // code 11 dropped: frames keep 8O2 shape
    cfg_write(7'h03);
    send_tx(8'h3C, 1'b1, "R2 bad code ignored");
    chk("R2 queue drained", exp_q.size(), 0);

    // R4: pending write overwritten
    cfg_write(7'h60);
    n_empty = 0; n_done = 0;
    exp_q.push_back(8'h11);
    exp_q.push_back(8'h33);
    @(negedge clk); tx_we = 1'b1; tx_wdata = 8'h11;
    @(negedge clk); tx_wdata = 8'h22;
    @(negedge clk); tx_wdata = 8'h33;
    @(negedge clk); tx_we = 1'b0;
    for (int i = 0; i < 800 && n_done < 2; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R4 two loads after overwrite", n_empty, 2);
    chk("R4 two frames sent", n_done, 2);
    chk("R4 overwritten char not sent", exp_q.size(), 0);

    // parity error via direct drive, 8E1 with check
    loop_en = 1'b0;
    cfg_write(7'h6A);
    exp_q.push_back(8'h33);
    send_raw(8'h33, 1'b1, 1'b1);
    chk("R8 parity error flagged", err_parity, 1'b1);
    chk("R8 char still delivered", exp_q.size(), 0);
    chk("R9 no framing error", err_frame, 1'b0);
    exp_q.push_back(8'h44);
    send_raw(8'h44, 1'b0, 1'b1);
    chk("R11 parity flag stays after read", err_parity, 1'b1);
    cmd_write(5'b01000);
    chk("R11 parity flag cleared", err_parity, 1'b0);
    cfg_write(7'h62);
    exp_q.push_back(8'h55);
    send_raw(8'h55, 1'b1, 1'b1);
    chk("R8 no flag when check off", err_parity, 1'b0);

    // framing error
    cfg_write(7'h60);
    exp_q.push_back(8'h81);
    send_raw(8'h81, 1'b0, 1'b0);
    chk("R9 framing error flagged", err_frame, 1'b1);
    cmd_write(5'b00100);
    chk("R11 framing flag cleared", err_frame, 1'b0);
    cfg_write(7'h40);
    exp_q.push_back(8'h18);
    send_raw(8'h18, 1'b0, 1'b0);
    chk("R9 no flag when check off", err_frame, 1'b0);

    // R6 short low pulse ignored, then a real frame still received
    drv_rxd = 1'b0;
    repeat (4) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk("R6 glitch ignored", rx_valid, 1'b0);
    exp_q.push_back(8'hC6);
    send_raw(8'hC6, 1'b0, 1'b1);
    chk("R6 frame after glitch", exp_q.size(), 0);

    // overrun with check on
    loop_en = 1'b1;
    auto_rd = 1'b0;
    cfg_write(7'h60);
    send_tx(8'hA1, 1'b0, "R10 first");
    send_tx(8'hB2, 1'b0, "R10 second");
    chk("R10 overrun flagged", err_overrun, 1'b1);
    chk("R10 old char kept", rx_data, 8'hA1);
    chk("R12 buffer still valid", rx_valid, 1'b1);
    read_buf();
    chk("R12 read empties buffer", rx_valid, 1'b0);
    cmd_write(5'b10000);
    chk("R11 overrun flag cleared", err_overrun, 1'b0);

    // overrun with check off
    cfg_write(7'h20);
    send_tx(8'hC3, 1'b0, "R10 first nocheck");
    send_tx(8'hD4, 1'b0, "R10 second nocheck");
    chk("R10 no flag when check off", err_overrun, 1'b0);
    chk("R10 old char kept nocheck", rx_data, 8'hC3);
    read_buf();

    // R11 set and clear in the same cycle: set wins
    cfg_write(7'h60);
    send_tx(8'h0F, 1'b0, "R11 fill");
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = 5'b10000;
    seen_oe = 1'b0; watch_oe = 1'b1;
    send_tx(8'hF0, 1'b0, "R11 collide");
    watch_oe = 1'b0;
    cmd_we = 1'b0; cmd_wdata = '0;
    repeat (2) @(negedge clk);
    chk("R11 set wins over held clear", seen_oe, 1'b1);
    chk("R11 clear after release", err_overrun, 1'b0);
    chk("R10 first char kept", rx_data, 8'h0F);
    read_buf();

    // receiver off again
    auto_rd = 1'b1;
    cmd_write(5'b00010);
    chk("R5 receiver off", rx_enabled, 1'b0);
    send_tx(8'h77, 1'b0, "R5 off frame");
    chk("R5 nothing received after off", rx_valid, 1'b0);
    chk("scoreboard empty", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule